// File: doc/BRIEF.md
# Multi-format audio serial port

This block moves audio samples between the core and the outside world. It has four stereo playback data inputs and one capture data output. All of them share one bit clock and one frame clock. One engine handles five framings: I2S, left-justified, right-justified, a two-slot DSP framing with a pulse, and an eight-slot TDM framing. The word length is 16, 20 or 24 bits.

As clock master, the block divides its system clock down to a bit clock and builds the frame clock from it. As slave, it takes both clocks from outside through synchronizers. In both cases the same edge-detected clocks drive the single receive and transmit engine, which runs in the system clock domain.

Received words go to the core as MSB-aligned 24-bit values, one port per data line, each with a channel index and a one-cycle valid. Capture words are written by the core into eight slot registers, and the transmitter reads them out slot by slot.

Top module: `aud_serial_port`

## Requirements
- R1: While reset is held and right after it, `sdout_o` is 0, `pb_valid_o` is all zero, `bclk_o` is 1 and `fclk_o` is 0.
- R2: With `master_i`=1, `bclk_o` toggles every HALF_DIV system clocks, so a bit lasts 2*HALF_DIV clocks. `fclk_o` changes only together with a falling `bclk_o`. Bit 0 of the first frame begins at the first falling edge after `master_i` rises.
- R3: With `master_i`=0, `bclk_o` stays 1, `fclk_o` stays 0 and `clk_drive_o` is 0. Timing comes from `bclk_i` and `fclk_i`.
- R4: Left-justified (`fmt_i`=1). Frame clock high marks the left half, and the MSB is in the first bit after the frame clock rises. The frame is 64 bits, 32 per half. On a line L (0..3), left is channel 2L and right is channel 2L+1.
- R5: I2S (`fmt_i`=0). Frame clock low marks the left half, and the MSB comes one bit after the frame clock falls.
- R6: Right-justified (`fmt_i`=2). The frame clock is the same as in R4. The LSB sits in the last bit of each 32-bit half.
- R7: DSP (`fmt_i`=3). A one-bit-wide high pulse on the frame clock marks bit 0. The MSB of slot 0 is in bit 1, and slot 1 starts 32 bits later, in a 64-bit frame.
- R8: TDM (`fmt_i`=4). The frame is 256 bits, with eight 32-bit slots on data line 0, framed as in R7. Slot k is channel k. Lines 1..3 are ignored, and no word is reported on their ports. `sdout_o` carries the eight capture slots.
- R9: The word length `wl_i` is 0 for 16 bits, 1 for 20 and 2 for 24. Received words appear MSB-aligned in 24 bits with the unused low bits at 0. Transmit bits outside the word are 0.
- R10: `sdout_o` changes only after a falling bit clock. Inputs are sampled at the rising bit clock, and a received word is reported only after a rising edge.
- R11: A pulse of `cap_valid_i` writes `cap_data_i` into capture slot `cap_chan_i`. The transmitter sends slot k in TDM. In the other formats it sends slot 0 in the left half and slot 1 in the right.
- R12: Until the first frame start is detected, no word is reported and `sdout_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| master_i | input | 1 | 1 = block drives bit and frame clocks |
| fmt_i | input | 3 | Framing select (0 I2S, 1 LJ, 2 RJ, 3 DSP, 4 TDM) |
| wl_i | input | 2 | Word length (0:16, 1:20, 2:24) |
| bclk_i | input | 1 | External bit clock (slave) |
| fclk_i | input | 1 | External frame clock (slave) |
| sdin_i | input | 4 | Playback serial data lines |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Generated frame clock |
| clk_drive_o | output | 1 | Output enable for the clock pins |
| sdout_o | output | 1 | Capture serial data |
| pb_valid_o | output | 4 | Word valid, one per line |
| pb_chan_o | output | 12 | Channel index, 3 bits per line |
| pb_data_o | output | 96 | Received word, 24 bits per line, MSB-aligned |
| cap_valid_i | input | 1 | Capture slot write strobe |
| cap_chan_i | input | 3 | Capture slot index |
| cap_data_i | input | 24 | Capture word, MSB-aligned |

## Verification
The hardest state to reach from the ports is the steady state of a long TDM frame in which all eight slots are checked bit by bit. The unused lines must carry noise, and the first frame must be discarded, because the engine only locks at a detected frame start. The bench plays the external audio device. It either generates the clocks itself or follows `bclk_o`, and it drives each bit after a falling edge. It runs three frames per scenario and checks the capture stream only in the last one, by which time lock is certain. The I2S cases need care: the frame clock is low at bit 0, so lock only happens one frame later, and the bench must not expect words from the first frame.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int LANES     = 4;
  localparam int NSLOT_MAX = 8;
  localparam int POS_W     = 8;

  typedef enum logic [2:0] {
    FMT_I2S = 3'd0,
    FMT_LJ  = 3'd1,
    FMT_RJ  = 3'd2,
    FMT_DSP = 3'd3,
    FMT_TDM = 3'd4
  } fmt_e;

  function automatic int word_len(logic [1:0] wl);
    case (wl)
      2'd0:    return 16;
      2'd1:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] pos_mask(fmt_e f);
    return (f == FMT_TDM) ? 8'hFF : 8'h3F;
  endfunction

  // first data bit inside a 32-bit slot
  function automatic int slot_offset(fmt_e f, logic [1:0] wl);
    case (f)
      FMT_LJ:  return 0;
      FMT_RJ:  return 32 - word_len(wl);
      default: return 1;
    endcase
  endfunction

  function automatic logic frame_level(fmt_e f, logic [POS_W-1:0] p);
    case (f)
      FMT_I2S:        return p[5];
      FMT_LJ, FMT_RJ: return ~p[5];
      default:        return (p == '0);
    endcase
  endfunction

  function automatic logic start_edge(fmt_e f, logic cur, logic prev);
    return (f == FMT_I2S) ? (prev & ~cur) : (cur & ~prev);
  endfunction

  function automatic logic [2:0] slot_of(fmt_e f, logic [POS_W-1:0] p);
    return (f == FMT_TDM) ? p[7:5] : {2'b00, p[5]};
  endfunction

  function automatic int bit_index(fmt_e f, logic [1:0] wl, logic [POS_W-1:0] p);
    return int'(p[4:0]) - slot_offset(f, wl);
  endfunction

  function automatic logic [SAMPLE_W-1:0] msb_align(logic [SAMPLE_W-1:0] v, logic [1:0] wl);
    return v << (SAMPLE_W - word_len(wl));
  endfunction
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/asp_clkgen.sv
module asp_clkgen
  import asp_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  fmt_e fmt,
  output logic bclk,
  output logic fclk
);
  localparam int CW = $clog2(HALF_DIV) + 1;

  logic [CW-1:0]    cnt;
  logic [POS_W-1:0] gpos;
  logic [POS_W-1:0] gnext;

  assign gnext = (gpos + 8'd1) & pos_mask(fmt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b1;
      fclk <= 1'b0;
      gpos <= '1;
    end else if (!en) begin
      cnt  <= '0;
      bclk <= 1'b1;
      fclk <= 1'b0;
      gpos <= '1;
    end else if (cnt == CW'(HALF_DIV - 1)) begin
      cnt  <= '0;
      bclk <= ~bclk;
      if (bclk) begin
        gpos <= gnext;
        fclk <= frame_level(fmt, gnext);
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/asp_rx_lane.sv
module asp_rx_lane
  import asp_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                sdi,
  input  logic [POS_W-1:0]    pos,
  input  fmt_e                fmt,
  input  logic [1:0]          wl,
  output logic                valid,
  output logic [2:0]          chan,
  output logic [SAMPLE_W-1:0] data
);
  logic [SAMPLE_W-1:0] sr;
  logic [SAMPLE_W-1:0] sr_next;
  logic [2:0]          slot;
  logic                active;
  logic                last_bit;
  int                  j;

  always_comb begin
    j        = bit_index(fmt, wl, pos);
    slot     = slot_of(fmt, pos);
    active   = en && (j >= 0) && (j < word_len(wl)) && (fmt != FMT_TDM || LANE == 0);
    last_bit = (j == word_len(wl) - 1);
    sr_next  = {sr[SAMPLE_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      valid <= 1'b0;
      chan  <= '0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      if (active) begin
        sr <= sr_next;
        if (last_bit) begin
          valid <= 1'b1;
          data  <= msb_align(sr_next, wl);
          chan  <= (fmt == FMT_TDM) ? slot : (3'(2 * LANE) | slot);
        end
      end
    end
  end
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [POS_W-1:0]    pos,
  input  fmt_e                fmt,
  input  logic [1:0]          wl,
  input  logic                cap_valid,
  input  logic [2:0]          cap_chan,
  input  logic [SAMPLE_W-1:0] cap_data,
  output logic                sdout
);
  logic [SAMPLE_W-1:0] hold [NSLOT_MAX];
  logic [2:0]          slot;
  logic                tx_bit;
  int                  j;

  always_comb begin
    j      = bit_index(fmt, wl, pos);
    slot   = slot_of(fmt, pos);
    tx_bit = 1'b0;
    if (j >= 0 && j < word_len(wl)) tx_bit = hold[slot][5'(SAMPLE_W - 1 - j)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT_MAX; k++) hold[k] <= '0;
      sdout <= 1'b0;
    end else begin
      if (cap_valid) hold[cap_chan] <= cap_data;
      if (en) sdout <= tx_bit;
    end
  end
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import asp_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      master_i,
  input  logic [2:0]                fmt_i,
  input  logic [1:0]                wl_i,
  input  logic                      bclk_i,
  input  logic                      fclk_i,
  input  logic [LANES-1:0]          sdin_i,
  output logic                      bclk_o,
  output logic                      fclk_o,
  output logic                      clk_drive_o,
  output logic                      sdout_o,
  output logic [LANES-1:0]          pb_valid_o,
  output logic [LANES*3-1:0]        pb_chan_o,
  output logic [LANES*SAMPLE_W-1:0] pb_data_o,
  input  logic                      cap_valid_i,
  input  logic [2:0]                cap_chan_i,
  input  logic [SAMPLE_W-1:0]       cap_data_i
);
  fmt_e fmt;
  assign fmt = fmt_e'(fmt_i);

  // external inputs, all through the same synchronizer depth
  logic [LANES+1:0] ext_s;
  logic [LANES-1:0] sdin_s;
  logic             bclk_s, fclk_s;

  asp_sync #(.W(LANES + 2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bclk_i, fclk_i, sdin_i}), .q(ext_s)
  );
  assign {bclk_s, fclk_s, sdin_s} = ext_s;

  logic bclk_m, fclk_m;
  asp_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(master_i), .fmt(fmt), .bclk(bclk_m), .fclk(fclk_m)
  );

  // one engine for both clocking modes
  logic             bclk_int, fclk_int, bclk_d, fprev;
  logic             bit_rise, bit_fall, frame_start, locked, locked_now;
  logic [POS_W-1:0] pos, pos_now, tx_pos;

  assign bclk_int    = master_i ? bclk_m : bclk_s;
  assign fclk_int    = master_i ? fclk_m : fclk_s;
  assign bit_rise    = bclk_int & ~bclk_d;
  assign bit_fall    = ~bclk_int & bclk_d;
  assign frame_start = bit_rise & start_edge(fmt, fclk_int, fprev);
  assign pos_now     = frame_start ? '0 : ((pos + 8'd1) & pos_mask(fmt));
  assign locked_now  = locked | frame_start;
  assign tx_pos      = (pos + 8'd1) & pos_mask(fmt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b1;
      fprev  <= 1'b0;
      pos    <= '1;
      locked <= 1'b0;
    end else begin
      bclk_d <= bclk_int;
      if (bit_rise) begin
        fprev <= fclk_int;
        pos   <= pos_now;
        if (frame_start) locked <= 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    asp_rx_lane #(.LANE(l)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(bit_rise & locked_now), .sdi(sdin_s[l]),
      .pos(pos_now), .fmt(fmt), .wl(wl_i),
      .valid(pb_valid_o[l]), .chan(pb_chan_o[l*3 +: 3]),
      .data(pb_data_o[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  asp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(bit_fall & locked), .pos(tx_pos), .fmt(fmt), .wl(wl_i),
    .cap_valid(cap_valid_i), .cap_chan(cap_chan_i), .cap_data(cap_data_i), .sdout(sdout_o)
  );

  assign bclk_o      = bclk_m;
  assign fclk_o      = fclk_m;
  assign clk_drive_o = master_i;
endmodule

// File: rtl/asp_chk.sv
module asp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        master_i,
  input logic [2:0]  fmt_i,
  input logic [1:0]  wl_i,
  input logic        bclk_o,
  input logic        fclk_o,
  input logic        sdout_o,
  input logic [3:0]  pb_valid_o,
  input logic [11:0] pb_chan_o,
  input logic [95:0] pb_data_o,
  input logic        bit_rise,
  input logic        bit_fall,
  input logic        locked
);
  p_idle_before_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (pb_valid_o == 4'b0 && !sdout_o));

  p_word_after_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_valid_o != 4'b0) |-> $past(bit_rise));

  p_sdout_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout_o) |-> $past(bit_fall));

  p_fclk_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && !$stable(fclk_o)) |-> $fell(bclk_o));

  p_slave_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |-> (bclk_o && !fclk_o));

  p_tdm_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == 3'd4) |-> (pb_valid_o[3:1] == 3'b0));

  p_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_valid_o[0] && wl_i == 2'd0) |-> (pb_data_o[7:0] == 8'h00));

  p_lane_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_valid_o[1] && fmt_i != 3'd4) |-> (pb_chan_o[5:4] == 2'b01));
endmodule

bind aud_serial_port asp_chk u_asp_chk (
  .clk(clk), .rst_n(rst_n), .master_i(master_i), .fmt_i(fmt_i), .wl_i(wl_i),
  .bclk_o(bclk_o), .fclk_o(fclk_o), .sdout_o(sdout_o), .pb_valid_o(pb_valid_o),
  .pb_chan_o(pb_chan_o), .pb_data_o(pb_data_o), .bit_rise(bit_rise),
  .bit_fall(bit_fall), .locked(locked)
);

// File: tb/test_aud_serial_port.sv
`timescale 1ns/1ps
module test_aud_serial_port;
  localparam int HALF = 8;      // slave half bit period in clk cycles
  localparam int MDIV = 4;      // master HALF_DIV

  logic        clk = 1'b0;
  logic        rst_n, master, bclk_in, fclk_in, cap_valid;
  logic [2:0]  fmt, cap_chan;
  logic [1:0]  wl;
  logic [3:0]  sdin;
  logic [23:0] cap_data;
  logic        bclk_o, fclk_o, clk_drive, sdout;
  logic [3:0]  pb_valid;
  logic [11:0] pb_chan;
  logic [95:0] pb_data;

  always #5 clk = ~clk;

  aud_serial_port #(.HALF_DIV(MDIV)) i_aud_serial_port (
    .clk(clk), .rst_n(rst_n), .master_i(master), .fmt_i(fmt), .wl_i(wl),
    .bclk_i(bclk_in), .fclk_i(fclk_in), .sdin_i(sdin), .bclk_o(bclk_o), .fclk_o(fclk_o),
    .clk_drive_o(clk_drive), .sdout_o(sdout), .pb_valid_o(pb_valid), .pb_chan_o(pb_chan),
    .pb_data_o(pb_data), .cap_valid_i(cap_valid), .cap_chan_i(cap_chan), .cap_data_i(cap_data)
  );

  int nchk = 0, nfail = 0, tdm_extra = 0, cyc = 0;
  bit done = 0;
  logic [23:0] pbw [8];
  logic [23:0] capw [8];
  logic [23:0] got [8];
  int          gotn [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bench view of the framing rules
  function automatic int bw(input logic [1:0] w);
    return (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : 24;
  endfunction
  function automatic int bframe(input logic [2:0] f);
    return (f == 3'd4) ? 256 : 64;
  endfunction
  function automatic int bstart(input logic [2:0] f, input logic [1:0] w);
    if (f == 3'd1) return 0;
    if (f == 3'd2) return 32 - bw(w);
    return 1;
  endfunction
  function automatic logic blevel(input logic [2:0] f, input int p);
    if (f == 3'd0) return (p % 64) >= 32;
    if (f <= 3'd2) return (p % 64) < 32;
    return p == 0;
  endfunction
  function automatic logic line_bit(input logic [2:0] f, input logic [1:0] w, input int lane, input int p);
    int s = p / 32;
    int k = (p % 32) - bstart(f, w);
    logic [23:0] word;
    if (f == 3'd4 && lane != 0) return 1'b1;     // noise on ignored lines
    if (k < 0 || k >= bw(w)) return 1'b0;
    word = (f == 3'd4) ? pbw[s] : pbw[2 * lane + s];
    return word[23 - k];
  endfunction
  function automatic logic out_bit(input logic [2:0] f, input logic [1:0] w, input int p);
    int s = p / 32;
    int k = (p % 32) - bstart(f, w);
    if (k < 0 || k >= bw(w)) return 1'b0;
    return capw[s][23 - k];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 4; l++) begin
        if (pb_valid[l]) begin
          got[pb_chan[l*3 +: 3]]  = pb_data[l*24 +: 24];
          gotn[pb_chan[l*3 +: 3]] = gotn[pb_chan[l*3 +: 3]] + 1;
          if (fmt == 3'd4 && l != 0) tdm_extra++;
        end
      end
    end
  end

  task automatic setup(input logic [2:0] f, input logic [1:0] w, input int seed);
    for (int i = 0; i < 8; i++) begin
      pbw[i]  = {8'(i * 37 + seed), 8'hC3 ^ 8'(seed), 8'(i * 91 + 5)};
      capw[i] = {8'(i * 29 + 3 * seed) | 8'h01, 8'h5A ^ 8'(i), 8'(seed * 7 + i)};
      got[i]  = '0;
      gotn[i] = 0;
    end
    tdm_extra = 0;
    @(negedge clk);
    rst_n = 1'b0; master = 1'b0; fmt = f; wl = w;
    bclk_in = 1'b1; fclk_in = 1'b0; sdin = '0; cap_valid = 1'b0; cap_chan = '0; cap_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      cap_valid = 1'b1; cap_chan = 3'(c); cap_data = capw[c];
    end
    @(negedge clk);
    cap_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_words(input logic [2:0] f, input logic [1:0] w, input string tag);
    logic [23:0] m = 24'hFFFFFF << (24 - bw(w));
    repeat (12) @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      check(gotn[c] > 0, {tag, " word seen"}, 32'(gotn[c]), 32'd1);
      check(got[c] == (pbw[c] & m), {tag, " word value"}, {8'(c), got[c]}, {8'(c), pbw[c] & m});
    end
    if (f == 3'd4) check(tdm_extra == 0, "R8 ignored lines", 32'(tdm_extra), 32'd0);
  endtask

  task automatic t_reset;
    setup(3'd1, 2'd2, 1);
    check(sdout == 1'b0 && pb_valid == 4'b0, "R1 reset outputs", {sdout, pb_valid}, 5'b0);
    check(bclk_o == 1'b1 && fclk_o == 1'b0, "R1 clock outputs", {bclk_o, fclk_o}, 2'b10);
    check(clk_drive == 1'b0, "R3 drive off", clk_drive, 1'b0);
    repeat (20) @(negedge clk);
    check(sdout == 1'b0 && pb_valid == 4'b0, "R12 idle without frame", {sdout, pb_valid}, 5'b0);
  endtask

  task automatic t_slave(input logic [2:0] f, input logic [1:0] w, input int seed, input string tag);
    int n = bframe(f);
    setup(f, w, seed);
    for (int fr = 0; fr < 3; fr++) begin
      for (int p = 0; p < n; p++) begin
        bclk_in = 1'b0;
        fclk_in = blevel(f, p);
        for (int l = 0; l < 4; l++) sdin[l] = line_bit(f, w, l, p);
        repeat (HALF) @(negedge clk);
        if (fr == 2)
          check(sdout == out_bit(f, w, p), {tag, " R10 R11 sdout bit"}, {24'(p), 7'b0, sdout},
                {24'(p), 7'b0, out_bit(f, w, p)});
        bclk_in = 1'b1;
        repeat (HALF) @(negedge clk);
      end
    end
    check(bclk_o == 1'b1 && fclk_o == 1'b0 && !clk_drive, "R3 slave clocks quiet",
          {bclk_o, fclk_o, clk_drive}, 3'b100);
    check_words(f, w, tag);
  endtask

  task automatic t_master(input logic [2:0] f, input logic [1:0] w, input int seed, input string tag);
    int n = bframe(f);
    int last_fall = 0;
    logic pb;
    setup(f, w, seed);
    master = 1'b1;
    for (int fr = 0; fr < 3; fr++) begin
      for (int p = 0; p < n; p++) begin
        do begin pb = bclk_o; @(negedge clk); end while (!(pb && !bclk_o));
        if (fr > 0 || p > 0)
          if (fr == 2 && p < 4)
            check(cyc - last_fall == 2 * MDIV, "R2 bit period", 32'(cyc - last_fall), 32'(2 * MDIV));
        last_fall = cyc;
        for (int l = 0; l < 4; l++) sdin[l] = line_bit(f, w, l, p);
        do begin pb = bclk_o; @(negedge clk); end while (!(!pb && bclk_o));
        if (fr == 2) begin
          check(fclk_o == blevel(f, p), {tag, " R2 frame clock"}, {24'(p), 7'b0, fclk_o},
                {24'(p), 7'b0, blevel(f, p)});
          check(sdout == out_bit(f, w, p), {tag, " R10 R11 sdout bit"}, {24'(p), 7'b0, sdout},
                {24'(p), 7'b0, out_bit(f, w, p)});
        end
      end
    end
    check(clk_drive == 1'b1, "R2 drive on", clk_drive, 1'b1);
    check_words(f, w, tag);
  endtask

  initial begin
    t_reset();
    t_slave(3'd1, 2'd2, 11, "R4 LJ24");
    t_slave(3'd0, 2'd0, 23, "R5 R9 I2S16");
    t_slave(3'd2, 2'd1, 37, "R6 R9 RJ20");
    t_slave(3'd3, 2'd2, 41, "R7 DSP24");
    t_slave(3'd4, 2'd2, 53, "R8 TDM24");
    t_master(3'd0, 2'd2, 67, "R2 R5 I2S24m");
    t_master(3'd4, 2'd0, 79, "R2 R8 R9 TDM16m");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule